// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block holds a small set of receive mailboxes that sit behind a CAN protocol engine. The engine presents each decoded frame for a single cycle as a strobe. The strobe carries the identifier, the extended-format flag, the remote-request flag, the length code and eight data bytes. The bank stores the frame in the lowest-numbered mailbox that is set to receive and still empty. A stored mailbox keeps its contents until the host re-arms it by writing a bitmask to a transfer-command register. A mailbox set to the overwrite receive mode is used only when no empty mailbox remains. It accepts the frame even when it is already full, and records that a message was lost.

The host reaches the bank through a simple word-addressed register port. Global registers hold the interrupt mask, with separate write-one enable and disable addresses, a status word and the re-arm command. Each mailbox has its own window that holds a mode word, the identifier, a status word and two data words. The interrupt output is high while any stored mailbox has its mask bit set. When no mailbox can take a frame, the frame is dropped and a sticky overflow bit is set. A read of the status word clears that bit.

Top module: `rx_mailbox_bank`

## Requirements
- R1: Each mailbox mode is a 3-bit value written and read back at bits 26:24 of the mailbox's mode word (offset 0x00 of the window at 0x200 + 0x20*index). Only 1 (receive) and 2 (receive with overwrite) accept frames. 0, 3, 4 and 5 never accept frames.
- R2: A frame is stored in the lowest-indexed mailbox whose mode is 1 or 2 and whose ready flag is clear.
- R3: Storing a frame sets the mailbox ready flag (bit 23 of its status word at offset 0x08). It also sets bit i of the global status word at 0x00C.
- R4: A mailbox in mode 1 with ready set takes no further frames, and its contents stay unchanged until it is re-armed.
- R5: Writing the transfer-command register (0x010) re-arms every mailbox whose bit is 1 and clears its ready and missed flags. Mailboxes whose bit is 0 are unaffected.
- R6: If no empty receive mailbox exists, the lowest-indexed full mode-2 mailbox takes the frame and sets its missed flag (status bit 24).
- R7: The identifier word (offset 0x04) holds an extended 29-bit ID in bits 28:0 with the extended flag at bit 29. A standard 11-bit ID is held in bits 28:18 with bit 29 clear.
- R8: The mailbox status word shows RTR at bit 20 and the length code at bits 19:16. Data bytes 0..3 are read from offset 0x0C and bytes 4..7 from offset 0x10, with byte 0 in bits 7:0.
- R9: Writing ones to 0x000 sets mask bits and writing ones to 0x004 clears them. The mask reads back at 0x008. irq is high exactly when some mailbox has both its ready flag and its mask bit set.
- R10: A frame that no mailbox can take is dropped and sets bit 31 of the global status word. That bit stays set until a status read, which returns it as 1 and then clears it.
- R11: After reset all modes, flags, the mask and the overflow bit are zero and irq is low.
- R12: Read data appears on host_rdata in the cycle after host_rd is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle strobe of a decoded frame |
| frm_id | input | 29 | Frame identifier (standard ID in bits 10:0) |
| frm_ide | input | 1 | Extended-format flag |
| frm_rtr | input | 1 | Remote-request flag |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 12 | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
A frame strobe sampled at a rising edge changes the ready flag, the global status bits and irq right after that edge. A re-arm or mask write takes effect right after its own edge in the same way. Read data becomes valid one edge after the read strobe. The overflow clear caused by a status read takes effect at that same edge, so the read still returns the old value. The bench drives every input at the falling edge and updates its reference model at the rising edge that samples the input. It compares irq and every read result at the following falling edge, which is exactly where each result is due.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

  typedef enum logic [2:0] {
    MB_OFF    = 3'd0,
    MB_RX     = 3'd1,
    MB_RX_OVR = 3'd2,
    MB_TX     = 3'd3,
    MB_CONS   = 3'd4,
    MB_PROD   = 3'd5
  } mb_mode_e;

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } rx_frame_t;

  localparam logic [11:0] REG_IEN    = 12'h000;
  localparam logic [11:0] REG_IDIS   = 12'h004;
  localparam logic [11:0] REG_IMASK  = 12'h008;
  localparam logic [11:0] REG_STATUS = 12'h00C;
  localparam logic [11:0] REG_XFER   = 12'h010;

  localparam logic [2:0] MB_REGION  = 3'b001;
  localparam logic [2:0] MBW_MODE   = 3'd0;
  localparam logic [2:0] MBW_ID     = 3'd1;
  localparam logic [2:0] MBW_STAT   = 3'd2;
  localparam logic [2:0] MBW_DLO    = 3'd3;
  localparam logic [2:0] MBW_DHI    = 3'd4;

  function automatic logic [31:0] id_word(input rx_frame_t f);
    if (f.ide) return {2'b00, 1'b1, f.id};
    return {3'b000, f.id[10:0], 18'd0};
  endfunction

  function automatic logic [31:0] stat_word(input logic miss, input logic rdy,
                                            input logic rtr, input logic [3:0] dlc);
    return {7'd0, miss, rdy, 2'b00, rtr, dlc, 16'd0};
  endfunction

  function automatic logic [31:0] mode_word(input logic [2:0] m);
    return {5'd0, m, 24'd0};
  endfunction

endpackage

// File: rtl/rxmb_alloc.sv
module rxmb_alloc #(
  parameter int NUM_MB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [NUM_MB-1:0] rx_en,
  input  logic [NUM_MB-1:0] ovr_en,
  input  logic [NUM_MB-1:0] ready,
  output logic [NUM_MB-1:0] store_vec,
  output logic              drop
);

  function automatic logic [NUM_MB-1:0] lowest_bit(input logic [NUM_MB-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  logic [NUM_MB-1:0] free_v;
  logic [NUM_MB-1:0] full_ovr_v;

  assign free_v     = rx_en & ~ready;
  assign full_ovr_v = ovr_en & ready;

  always_comb begin
    store_vec = '0;
    drop      = 1'b0;
    if (frm_valid) begin
      if (|free_v)          store_vec = lowest_bit(free_v);
      else if (|full_ovr_v) store_vec = lowest_bit(full_ovr_v);
      else                  drop = 1'b1;
    end
  end

  // R2
  prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (|free_v)) |-> ($onehot(store_vec) &&
      ((store_vec & ~free_v) == '0) && (((store_vec - 1'b1) & free_v) == '0)));

  // R6
  ovr_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && free_v == '0 && (|full_ovr_v)) |->
      ($onehot(store_vec) && ((store_vec & ~full_ovr_v) == '0)));

endmodule

// File: rtl/rxmb_slot.sv
module rxmb_slot
  import rxmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [2:0]  mode_in,
  input  logic        store,
  input  rx_frame_t   frm,
  input  logic        rearm,
  output logic [2:0]  mode_q,
  output logic        ready_q,
  output logic        missed_q,
  output logic [31:0] id_q,
  output logic        rtr_q,
  output logic [3:0]  dlc_q,
  output logic [31:0] dlo_q,
  output logic [31:0] dhi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 3'd0;
      ready_q  <= 1'b0;
      missed_q <= 1'b0;
      id_q     <= '0;
      rtr_q    <= 1'b0;
      dlc_q    <= '0;
      dlo_q    <= '0;
      dhi_q    <= '0;
    end else begin
      if (mode_we) mode_q <= mode_in;
      if (store) begin
        id_q     <= id_word(frm);
        rtr_q    <= frm.rtr;
        dlc_q    <= frm.dlc;
        dlo_q    <= frm.data[31:0];
        dhi_q    <= frm.data[63:32];
        ready_q  <= 1'b1;
        missed_q <= ready_q;
      end else if (rearm) begin
        ready_q  <= 1'b0;
        missed_q <= 1'b0;
      end
    end
  end

  // R3
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> ready_q);

  // R6
  missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store && ready_q) |=> missed_q);

  // R5
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !store) |=> (!ready_q && !missed_q));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !store && !rearm) |=> (ready_q && $stable(id_q) && $stable(dlo_q) && $stable(dhi_q)));

endmodule

// File: rtl/rx_mailbox_bank.sv
module rx_mailbox_bank
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid,
  input  logic [28:0] frm_id,
  input  logic        frm_ide,
  input  logic        frm_rtr,
  input  logic [3:0]  frm_dlc,
  input  logic [63:0] frm_data,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [11:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq
);

  localparam int IDX_W = 4;

  initial begin
    if (NUM_MB < 1 || NUM_MB > 16) $error("NUM_MB must be 1..16");
  end

  rx_frame_t frm_s;
  assign frm_s = {frm_id, frm_ide, frm_rtr, frm_dlc, frm_data};

  logic             mb_sel;
  logic [IDX_W-1:0] mb_idx;
  logic [2:0]       mb_reg;
  assign mb_sel = (host_addr[11:9] == MB_REGION);
  assign mb_idx = host_addr[8:5];
  assign mb_reg = host_addr[4:2];

  logic wr_ien, wr_idis, wr_xfer, rd_status;
  assign wr_ien    = host_wr && (host_addr == REG_IEN);
  assign wr_idis   = host_wr && (host_addr == REG_IDIS);
  assign wr_xfer   = host_wr && (host_addr == REG_XFER);
  assign rd_status = host_rd && (host_addr == REG_STATUS);

  logic [NUM_MB-1:0] rx_en, ovr_en, ready_v, missed_v, store_vec, rearm_vec, mode_we;
  logic [2:0]        mode_a [NUM_MB];
  logic [31:0]       id_a   [NUM_MB];
  logic              rtr_a  [NUM_MB];
  logic [3:0]        dlc_a  [NUM_MB];
  logic [31:0]       dlo_a  [NUM_MB];
  logic [31:0]       dhi_a  [NUM_MB];
  logic              drop;

  assign rearm_vec = wr_xfer ? host_wdata[NUM_MB-1:0] : '0;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    assign mode_we[i] = host_wr && mb_sel && (mb_idx == IDX_W'(i)) && (mb_reg == MBW_MODE);
    assign rx_en[i]   = (mode_a[i] == MB_RX) || (mode_a[i] == MB_RX_OVR);
    assign ovr_en[i]  = (mode_a[i] == MB_RX_OVR);

    rxmb_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (mode_we[i]),
      .mode_in  (host_wdata[26:24]),
      .store    (store_vec[i]),
      .frm      (frm_s),
      .rearm    (rearm_vec[i]),
      .mode_q   (mode_a[i]),
      .ready_q  (ready_v[i]),
      .missed_q (missed_v[i]),
      .id_q     (id_a[i]),
      .rtr_q    (rtr_a[i]),
      .dlc_q    (dlc_a[i]),
      .dlo_q    (dlo_a[i]),
      .dhi_q    (dhi_a[i])
    );
  end

  rxmb_alloc #(.NUM_MB(NUM_MB)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .rx_en     (rx_en),
    .ovr_en    (ovr_en),
    .ready     (ready_v),
    .store_vec (store_vec),
    .drop      (drop)
  );

  logic [NUM_MB-1:0] mask_q;
  logic              ovf_q;
  logic [31:0]       rdata_q;
  logic [31:0]       rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ien)       mask_q <= mask_q | host_wdata[NUM_MB-1:0];
      else if (wr_idis) mask_q <= mask_q & ~host_wdata[NUM_MB-1:0];
      if (drop)           ovf_q <= 1'b1;
      else if (rd_status) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (host_addr == REG_IMASK) begin
      rd_mux[NUM_MB-1:0] = mask_q;
    end else if (host_addr == REG_STATUS) begin
      rd_mux[NUM_MB-1:0] = ready_v;
      rd_mux[31]         = ovf_q;
    end else if (mb_sel) begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (mb_idx == IDX_W'(i)) begin
          case (mb_reg)
            MBW_MODE: rd_mux = mode_word(mode_a[i]);
            MBW_ID:   rd_mux = id_a[i];
            MBW_STAT: rd_mux = stat_word(missed_v[i], ready_v[i], rtr_a[i], dlc_a[i]);
            MBW_DLO:  rd_mux = dlo_a[i];
            MBW_DHI:  rd_mux = dhi_a[i];
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
  end

  assign host_rdata = rdata_q;
  assign irq        = |(ready_v & mask_q);

  logic unused_bits;
  assign unused_bits = &{1'b0, host_addr[1:0], host_wdata};

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);

  // R9
  mask_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> ((mask_q & $past(host_wdata[NUM_MB-1:0])) == $past(host_wdata[NUM_MB-1:0])));

endmodule

// File: tb/sim_rx_mailbox_bank.sv
`timescale 1ns/1ps
module sim_rx_mailbox_bank;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [28:0] frm_id = '0;
  logic        frm_ide = 1'b0;
  logic        frm_rtr = 1'b0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;

  always #10 clk = ~clk;

  rx_mailbox_bank #(.NUM_MB(N)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int          m_mode [N];
  bit          m_rdy  [N];
  bit          m_miss [N];
  logic [31:0] m_id   [N];
  bit          m_rtr  [N];
  int          m_dlc  [N];
  logic [31:0] m_lo   [N];
  logic [31:0] m_hi   [N];
  int          m_mask = 0;
  bit          m_ovf = 0;

  function automatic bit model_irq();
    for (int i = 0; i < N; i++) if (m_rdy[i] && m_mask[i]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [31:0] v;
    int k, w;
    v = 0;
    if (a == 12'h008) v = m_mask;
    else if (a == 12'h00C) begin
      for (int i = 0; i < N; i++) v[i] = m_rdy[i];
      v[31] = m_ovf;
    end else if (a >= 12'h200 && a < 12'h200 + 32 * N) begin
      k = (a - 12'h200) / 32;
      w = ((a - 12'h200) % 32) / 4;
      case (w)
        0: v = m_mode[k] << 24;
        1: v = m_id[k];
        2: v = (m_miss[k] << 24) | (m_rdy[k] << 23) | (m_rtr[k] << 20) | (m_dlc[k] << 16);
        3: v = m_lo[k];
        4: v = m_hi[k];
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9: irq compared against the model every cycle
  always @(negedge clk) begin
    if (rst_n) chk("R9 irq", {31'd0, irq}, {31'd0, model_irq()});
  end

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    int k;
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk);
    if (a == 12'h000) m_mask = m_mask | (d & ((1 << N) - 1));
    else if (a == 12'h004) m_mask = m_mask & ~d;
    else if (a == 12'h010) begin
      for (int i = 0; i < N; i++) if (d[i]) begin m_rdy[i] = 0; m_miss[i] = 0; end
    end else if (a >= 12'h200 && a < 12'h200 + 32 * N && a[4:0] == 0) begin
      k = (a - 12'h200) / 32;
      m_mode[k] = d[26:24];
    end
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic send_frame(input logic [28:0] id, input bit ide, input bit rtr,
                            input logic [3:0] dlc, input logic [63:0] data);
    int t;
    @(negedge clk);
    frm_valid = 1; frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_dlc = dlc; frm_data = data;
    @(posedge clk);
    t = -1;
    for (int i = 0; i < N; i++)
      if (t < 0 && (m_mode[i] == 1 || m_mode[i] == 2) && !m_rdy[i]) t = i;
    if (t < 0)
      for (int i = 0; i < N; i++)
        if (t < 0 && m_mode[i] == 2) t = i;
    if (t < 0) m_ovf = 1;
    else begin
      m_miss[t] = m_rdy[t];
      m_rdy[t]  = 1;
      m_id[t]   = ide ? ((32'd1 << 29) | id) : ({21'd0, id[10:0]} << 18);
      m_rtr[t]  = rtr;
      m_dlc[t]  = dlc;
      m_lo[t]   = data[31:0];
      m_hi[t]   = data[63:32];
    end
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic host_read(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    host_rd = 1; host_addr = a;
    @(posedge clk);
    exp = model_read(a);
    if (a == 12'h00C) m_ovf = 0;
    @(negedge clk);
    host_rd = 0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic check_mb(input int k, input string tag);
    logic [11:0] b;
    b = 12'(12'h200 + 32 * k);
    host_read(b,        {tag, " R1 mode"});
    host_read(b + 12'h4, {tag, " R7 id"});
    host_read(b + 12'h8, {tag, " R8 stat"});
    host_read(b + 12'hC, {tag, " R8 lo"});
    host_read(b + 12'h10, {tag, " R8 hi"});
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_mode[i] = 0; m_rdy[i] = 0; m_miss[i] = 0; m_id[i] = 0;
      m_rtr[i] = 0; m_dlc[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state, R12 read latency
    host_read(12'h00C, "R11 status");
    host_read(12'h008, "R12 mask");
    check_mb(0, "R11");

    // R10 nothing armed: drop, sticky bit, clear on read
    send_frame(29'h123, 0, 0, 4'd2, 64'h1111);
    host_read(12'h00C, "R10 ovf set");
    host_read(12'h00C, "R10 ovf cleared");

    // R1 modes: mb3 transmit, mb7 overwrite, others receive
    for (int i = 0; i < N; i++)
      host_write(12'(12'h200 + 32 * i), (i == 3) ? 32'h0300_0000 :
                 (i == N - 1) ? 32'h0200_0000 : 32'h0100_0000);
    host_read(12'h260, "R1 mode tx");
    host_write(12'h000, 32'h0000_0083);
    host_read(12'h008, "R9 mask");

    // R2 R3 fill: mb3 skipped
    send_frame(29'h1ABCDEF0, 1, 0, 4'd8, 64'h0807060504030201);
    send_frame(29'h7FF, 0, 1, 4'd0, 64'h0);
    send_frame(29'h055, 0, 0, 4'd3, 64'h00000000_00C0FFEE);
    send_frame(29'h0000_0001, 1, 0, 4'd15, 64'hDEADBEEF_CAFEF00D);
    send_frame(29'h2AA, 0, 0, 4'd1, 64'h55);
    send_frame(29'h100, 0, 1, 4'd7, 64'hFFFF_FFFF_0000_0000);
    host_read(12'h00C, "R3 status");
    send_frame(29'h321, 0, 0, 4'd4, 64'h44332211);
    // R6 overwrite of full mb7
    send_frame(29'h0ABCDE, 1, 0, 4'd6, 64'h0123456789ABCDEF);
    for (int i = 0; i < N; i++) check_mb(i, (i == N - 1) ? "R6" : "R4");

    // R5 multi re-arm
    host_write(12'h010, 32'h0000_0085);
    host_read(12'h00C, "R5 status");
    host_read(12'h2E8, "R5 mb7 stat");
    // R2 lowest re-armed mailbox wins
    send_frame(29'h3C3, 0, 0, 4'd5, 64'hAA);
    check_mb(0, "R2");
    send_frame(29'h0F0F0F, 1, 1, 4'd2, 64'hBB);
    check_mb(2, "R2");
    send_frame(29'h012, 0, 0, 4'd1, 64'hCC);
    send_frame(29'h013, 0, 0, 4'd1, 64'hDD);
    check_mb(N - 1, "R6");
    check_mb(1, "R4");

    // R9 disable
    host_write(12'h004, 32'h0000_0081);
    host_read(12'h008, "R9 mask dis");
    host_write(12'h004, 32'h0000_0002);
    host_read(12'h008, "R9 mask zero");

    // R10 all full with no overwrite mailbox
    host_write(12'(12'h200 + 32 * (N - 1)), 32'h0100_0000);
    send_frame(29'h777, 0, 0, 4'd2, 64'h99);
    host_read(12'h00C, "R10 full drop");
    host_read(12'h00C, "R10 cleared");
    check_mb(N - 1, "R4");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule